// File: doc/BRIEF.md
# SPI Register Block Transfer Engine

This block is an SPI master that moves blocks of register data to and from a peripheral. The host loads an operation code, an 8-bit register index and a byte count, then pulses `start`. The engine lowers chip-select and shifts out a four-byte command prefix. For a write it follows the prefix with payload bytes that it fetches from a host buffer through a byte-wide address/data port. For a read it follows the prefix with zero bytes and hands each received byte back through a second byte-wide port.

The link is full duplex. While the prefix goes out, the engine captures what the peripheral returns. The bytes that arrive in prefix slots 2 and 3 form an acknowledge pattern, and the engine checks them. When the transfer ends, chip-select is released and a one-cycle `done` pulse follows. The `error` flag reports a bad acknowledge or a rejected request, and it holds its value until the next accepted start.

The SCLK rate is set by the parameter `CLK_DIV`, which gives the number of system clocks in each half period. Requests with an illegal operation code or an oversized count are refused without touching the bus.

Top module: `spi_regxfer`

## Requirements
- R1: Every transfer begins with four bytes on MOSI: 0x00, 0xFF, the register index, then the operation code. Bytes are sent most significant bit first in SPI mode 0: SCLK idles low, MOSI is stable at the rising edge, and MISO is sampled on the rising edge.
- R2: Operation code 0x00 selects a write and 0x01 selects a read. Any other code sets `error` and produces a `done` pulse, and chip-select never goes low.
- R3: A byte count above 128 is refused in the same way as R2: error, done, no bus activity. A count of exactly 128 is accepted.
- R4: A write of N bytes sends exactly 4+N bytes. Payload byte k (k = 0..N-1) is the `wr_data` value present while `wr_addr` equals k.
- R5: A read of N bytes sends 4+N bytes, and every byte after the prefix is 0x00 on MOSI. For each byte k received after the prefix, `rd_valid` pulses once with `rd_addr` = k and `rd_data` = that byte.
- R6: If the byte received in prefix slot 2 is not 0x62, or the byte in slot 3 is not 0x9D, the transfer still runs to its full length and ends with `error` = 1. If both match, `error` = 0.
- R7: Chip-select is low before the first SCLK rising edge and stays low through the whole frame, with no release between bytes. SCLK is low whenever chip-select is high.
- R8: `done` is high for exactly one clock, in the first cycle after chip-select returns high. `error` keeps its value after `done` until the next accepted start.
- R9: A start pulse that arrives while a transfer is in progress is ignored. The frame in flight is unchanged, and no second frame follows.
- R10: Each SCLK high phase lasts `CLK_DIV` system clocks, so a frame of B bytes holds SCLK high for 8·B·`CLK_DIV` clocks in total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request pulse, sampled only when idle |
| op_code | input | 8 | 0x00 write, 0x01 read, others rejected |
| reg_idx | input | 8 | Register index sent in prefix slot 2 |
| byte_len | input | LEN_W | Payload byte count (0..128 legal) |
| wr_addr | output | AW | Index of the payload byte being fetched |
| wr_data | input | 8 | Payload byte at `wr_addr`, read combinationally |
| rd_valid | output | 1 | One-cycle strobe for a received payload byte |
| rd_addr | output | AW | Index of the received byte |
| rd_data | output | 8 | Received payload byte |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Rejected request or bad acknowledge, held until the next start |
| sclk | output | 1 | SPI clock, idles low |
| mosi | output | 1 | Master data out |
| cs_n | output | 1 | Active-low chip-select |
| miso | input | 1 | Slave data in |

## Verification
The assertions check the following on every cycle:
- SCLK stays low while chip-select is high.
- `done` is a single-cycle pulse, and it coincides with a released chip-select.
- Received-byte strobes appear only during reads.
- The latched request fields stay frozen while a frame is in flight.
- SCLK changes only on divider ticks.

Other properties need a peripheral model and can only be shown by the bench scenarios:
- The exact byte stream on MOSI and the count of bytes in each frame.
- That data returned on MISO reaches the read port at the right index.
- That a corrupted acknowledge in either slot still gives a full-length frame ending in an error.
- That refused requests leave the bus quiet.

// File: rtl/spi_regxfer_pkg.sv
package spi_regxfer_pkg;
  localparam int          BYTE_W   = 8;
  localparam logic [7:0]  PRE_LEAD = 8'h00;
  localparam logic [7:0]  PRE_SYNC = 8'hFF;
  localparam logic [7:0]  ACK_LO   = 8'h62;
  localparam logic [7:0]  ACK_HI   = 8'h9D;
  localparam logic [7:0]  OPC_WR   = 8'h00;
  localparam logic [7:0]  OPC_RD   = 8'h01;
  localparam int          PRE_LEN  = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_FINISH
  } seq_state_e;
endpackage

// File: rtl/spi_regxfer_tick.sv
module spi_regxfer_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (DIV > 1) begin : g_spacing
      assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/spi_regxfer_shift.sv
module spi_regxfer_shift
  import spi_regxfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

  logic              busy_q, busy_d;
  logic              phase_q, phase_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic              done_q, done_d;

  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    bit_d   = bit_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    done_d  = 1'b0;
    if (load) begin
      busy_d  = 1'b1;
      phase_d = 1'b0;
      bit_d   = '0;
      tx_d    = tx_byte;
    end else if (busy_q && tick) begin
      if (!phase_q) begin
        phase_d = 1'b1;
        rx_d    = {rx_q[BYTE_W-2:0], miso};
      end else begin
        phase_d = 1'b0;
        if (bit_q == LAST_BIT) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
          tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      bit_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      done_q  <= done_d;
    end
  end

  assign busy      = busy_q;
  assign sclk      = phase_q;
  assign mosi      = tx_q[BYTE_W-1];
  assign byte_done = done_q;
  assign rx_byte   = rx_q;

  assert_sclk_moves_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(sclk));
  assert_sclk_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> busy);
endmodule

// File: rtl/spi_regxfer_seq.sv
module spi_regxfer_seq
  import spi_regxfer_pkg::*;
#(
  parameter int MAX_LEN = 128,
  parameter int LEN_W   = 8,
  parameter int AW      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        op_code,
  input  logic [7:0]        reg_idx,
  input  logic [LEN_W-1:0]  byte_len,
  output logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              sh_done,
  input  logic [BYTE_W-1:0] sh_rx,
  output logic              sh_load,
  output logic [BYTE_W-1:0] sh_tx,
  output logic              rd_valid,
  output logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data,
  output logic              cs_n,
  output logic              done,
  output logic              error
);
  localparam int IW = LEN_W + 1;
  localparam logic [IW-1:0] PRE_W = IW'(PRE_LEN);

  seq_state_e      st_q, st_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [7:0]      reg_q, reg_d;
  logic            rd_q, rd_d;
  logic            cs_q, cs_d;
  logic            err_q, err_d;
  logic            bad_q, bad_d;
  logic            rdv_q, rdv_d;
  logic [AW-1:0]   rda_q, rda_d;
  logic [7:0]      rdd_q, rdd_d;

  logic            req_ok;
  logic            last_byte;
  logic [IW-1:0]   pidx;

  assign req_ok    = ((op_code == OPC_WR) || (op_code == OPC_RD)) &&
                     (byte_len <= LEN_W'(MAX_LEN));
  assign last_byte = (idx_q == (IW'(len_q) + PRE_W - 1'b1));
  assign pidx      = idx_q - PRE_W;
  assign wr_addr   = pidx[AW-1:0];

  always_comb begin
    case (idx_q)
      IW'(0):  sh_tx = PRE_LEAD;
      IW'(1):  sh_tx = PRE_SYNC;
      IW'(2):  sh_tx = reg_q;
      IW'(3):  sh_tx = rd_q ? OPC_RD : OPC_WR;
      default: sh_tx = rd_q ? 8'h00 : wr_data;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    len_d   = len_q;
    reg_d   = reg_q;
    rd_d    = rd_q;
    cs_d    = cs_q;
    err_d   = err_q;
    bad_d   = bad_q;
    rdv_d   = 1'b0;
    rda_d   = rda_q;
    rdd_d   = rdd_q;
    sh_load = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (req_ok) begin
            len_d = byte_len;
            reg_d = reg_idx;
            rd_d  = (op_code == OPC_RD);
            idx_d = '0;
            cs_d  = 1'b0;
            err_d = 1'b0;
            bad_d = 1'b0;
            st_d  = ST_LOAD;
          end else begin
            err_d = 1'b1;
            st_d  = ST_FINISH;
          end
        end
      end
      ST_LOAD: begin
        sh_load = 1'b1;
        st_d    = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (sh_done) begin
          if ((idx_q == IW'(2)) && (sh_rx != ACK_LO)) bad_d = 1'b1;
          if ((idx_q == IW'(3)) && (sh_rx != ACK_HI)) bad_d = 1'b1;
          if (rd_q && (idx_q >= PRE_W)) begin
            rdv_d = 1'b1;
            rda_d = pidx[AW-1:0];
            rdd_d = sh_rx;
          end
          if (last_byte) begin
            cs_d  = 1'b1;
            err_d = bad_d;
            st_d  = ST_FINISH;
          end else begin
            idx_d = idx_q + 1'b1;
            st_d  = ST_LOAD;
          end
        end
      end
      ST_FINISH: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      len_q <= '0;
      reg_q <= '0;
      rd_q  <= 1'b0;
      cs_q  <= 1'b1;
      err_q <= 1'b0;
      bad_q <= 1'b0;
      rdv_q <= 1'b0;
      rda_q <= '0;
      rdd_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      len_q <= len_d;
      reg_q <= reg_d;
      rd_q  <= rd_d;
      cs_q  <= cs_d;
      err_q <= err_d;
      bad_q <= bad_d;
      rdv_q <= rdv_d;
      rda_q <= rda_d;
      rdd_q <= rdd_d;
    end
  end

  assign cs_n     = cs_q;
  assign done     = (st_q == ST_FINISH);
  assign error    = err_q;
  assign rd_valid = rdv_q;
  assign rd_addr  = rda_q;
  assign rd_data  = rdd_q;

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_cs_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
  assert_rd_strobe_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_q);
  assert_request_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && st_q != ST_IDLE) |=> ($stable(reg_q) && $stable(rd_q) && $stable(len_q)));
  assert_error_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start) |=> $stable(error));
endmodule

// File: rtl/spi_regxfer.sv
module spi_regxfer
  import spi_regxfer_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int MAX_LEN = 128,
  parameter int LEN_W   = 8,
  parameter int AW      = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       op_code,
  input  logic [7:0]       reg_idx,
  input  logic [LEN_W-1:0] byte_len,
  output logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             error,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  input  logic             miso
);
  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic              tick;
  logic              sh_busy;
  logic              sh_load;
  logic              sh_done;
  logic [BYTE_W-1:0] sh_tx;
  logic [BYTE_W-1:0] sh_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  spi_regxfer_tick #(.DIV(CLK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_i_n),
    .run   (sh_busy),
    .tick  (tick)
  );

  spi_regxfer_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .load      (sh_load),
    .tx_byte   (sh_tx),
    .tick      (tick),
    .miso      (miso),
    .busy      (sh_busy),
    .sclk      (sclk),
    .mosi      (mosi),
    .byte_done (sh_done),
    .rx_byte   (sh_rx)
  );

  spi_regxfer_seq #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (start),
    .op_code  (op_code),
    .reg_idx  (reg_idx),
    .byte_len (byte_len),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sh_done  (sh_done),
    .sh_rx    (sh_rx),
    .sh_load  (sh_load),
    .sh_tx    (sh_tx),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .cs_n     (cs_n),
    .done     (done),
    .error    (error)
  );

  assert_sclk_low_when_deselected_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    cs_n |-> !sclk);
  assert_cs_release_clean_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(cs_n) |-> (!sclk && !sh_busy));
endmodule

// File: tb/spi_regxfer_bench.sv
module spi_regxfer_bench;
  localparam int DIV = 3;
  localparam int LW  = 8;
  localparam int AWB = 7;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [7:0]     op_code = 8'h00;
  logic [7:0]     reg_idx = 8'h00;
  logic [LW-1:0]  byte_len = '0;
  logic [AWB-1:0] wr_addr;
  logic [7:0]     wr_data;
  logic           rd_valid;
  logic [AWB-1:0] rd_addr;
  logic [7:0]     rd_data;
  logic           done, error, sclk, mosi, cs_n;
  logic           miso = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [7:0] wmem [0:127];
  logic [7:0] resp [0:139];
  logic [7:0] mlog [0:139];
  logic [7:0] rbuf [0:127];
  int bitpos = 0;
  int cs_falls = 0;
  int rd_cnt = 0;
  logic last_sclk = 1'b0;

  int sclk_hi;
  int err_at_done;
  int done_after_cs;
  int done_single;

  always #10 clk = ~clk;

  assign wr_data = wmem[wr_addr];

  spi_regxfer #(.CLK_DIV(DIV), .MAX_LEN(128), .LEN_W(LW), .AW(AWB)) u_spi_regxfer (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code), .reg_idx(reg_idx),
    .byte_len(byte_len), .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .error(error), .sclk(sclk),
    .mosi(mosi), .cs_n(cs_n), .miso(miso)
  );

  // peripheral model: mode 0, drives MISO after falling edges, samples MOSI on rising
  always @(negedge cs_n or posedge sclk or negedge sclk) begin
    if (sclk && !last_sclk) begin
      mlog[bitpos/8] = {mlog[bitpos/8][6:0], mosi};
      bitpos = bitpos + 1;
    end else if (!sclk && last_sclk) begin
      if (bitpos < 1120) miso = resp[bitpos/8][7 - (bitpos % 8)];
    end else if (!cs_n) begin
      bitpos = 0;
      cs_falls = cs_falls + 1;
      miso = resp[0][7];
    end
    last_sclk = sclk;
  end

  always @(negedge clk) if (rd_valid) begin
    rbuf[rd_addr] = rd_data;
    rd_cnt = rd_cnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_resp(input logic [7:0] a2, input logic [7:0] a3);
    for (int i = 0; i < 140; i++) resp[i] = 8'((i * 37 + 11) & 8'hFF);
    resp[2] = a2;
    resp[3] = a3;
  endtask

  // issue one request; optional extra start pulse after `again` samples
  task automatic run_xfer(input logic [7:0] op, input logic [7:0] rg, input int len, input int again);
    int prev_cs;
    int n;
    @(negedge clk);
    op_code = op; reg_idx = rg; byte_len = LW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sclk_hi = 0; done_after_cs = 0; done_single = 0; err_at_done = -1;
    prev_cs = cs_n;
    n = 0;
    while (!done && n < 40000) begin
      if (sclk) sclk_hi++;
      if (again > 0 && n == again) begin
        op_code = 8'h01; reg_idx = 8'hEE; byte_len = LW'(1); start = 1'b1;
      end else start = 1'b0;
      prev_cs = cs_n;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (!done) chk("R8 done never seen", 0, 1);
    err_at_done = error;
    done_after_cs = (prev_cs == 0 && cs_n == 1) ? 1 : 0;
    @(negedge clk);
    done_single = !done;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R7 reset cs_n", cs_n, 1);
    chk("R7 reset sclk", sclk, 0);
    chk("R8 reset done", done, 0);
    chk("R8 reset error", error, 0);
  endtask

  task automatic t_write3;
    set_resp(8'h62, 8'h9D);
    wmem[0] = 8'hA1; wmem[1] = 8'h3C; wmem[2] = 8'h7E;
    run_xfer(8'h00, 8'h5A, 3, 0);
    chk("R1 prefix byte0", mlog[0], 8'h00);
    chk("R1 prefix byte1", mlog[1], 8'hFF);
    chk("R1 prefix reg", mlog[2], 8'h5A);
    chk("R1 prefix op write", mlog[3], 8'h00);
    chk("R4 payload0", mlog[4], 8'hA1);
    chk("R4 payload1", mlog[5], 8'h3C);
    chk("R4 payload2", mlog[6], 8'h7E);
    chk("R4 frame bits", bitpos, 7 * 8);
    chk("R10 sclk high clocks", sclk_hi, 7 * 8 * DIV);
    chk("R6 good ack error", err_at_done, 0);
    chk("R8 done after cs release", done_after_cs, 1);
    chk("R8 done one cycle", done_single, 1);
    chk("R7 sclk idle low", sclk, 0);
  endtask

  task automatic t_read5;
    int falls0;
    set_resp(8'h62, 8'h9D);
    rd_cnt = 0;
    falls0 = cs_falls;
    run_xfer(8'h01, 8'h21, 5, 0);
    chk("R7 one chip-select low per frame", cs_falls - falls0, 1);
    chk("R1 prefix op read", mlog[3], 8'h01);
    chk("R5 frame bits", bitpos, 9 * 8);
    for (int i = 0; i < 5; i++) begin
      chk("R5 mosi zero", mlog[4 + i], 8'h00);
      chk("R5 read data", rbuf[i], resp[4 + i]);
    end
    chk("R5 strobe count", rd_cnt, 5);
    chk("R6 good ack error", err_at_done, 0);
  endtask

  task automatic t_bad_ack;
    set_resp(8'h60, 8'h9D);
    run_xfer(8'h01, 8'h10, 2, 0);
    chk("R6 slot2 mismatch error", err_at_done, 1);
    chk("R6 full length on bad ack", bitpos, 6 * 8);
    repeat (20) @(negedge clk);
    chk("R8 error held", error, 1);
    set_resp(8'h62, 8'h9C);
    run_xfer(8'h00, 8'h11, 1, 0);
    chk("R6 slot3 mismatch error", err_at_done, 1);
    set_resp(8'h62, 8'h9D);
    run_xfer(8'h00, 8'h11, 0, 0);
    chk("R6 error cleared by good frame", err_at_done, 0);
    chk("R4 zero length frame bits", bitpos, 4 * 8);
  endtask

  task automatic t_reject;
    int falls0;
    falls0 = cs_falls;
    run_xfer(8'h02, 8'h33, 2, 0);
    chk("R2 bad opcode error", err_at_done, 1);
    chk("R2 bad opcode done single", done_single, 1);
    chk("R2 no chip-select", cs_falls - falls0, 0);
    chk("R2 no sclk", sclk_hi, 0);
    run_xfer(8'h00, 8'h33, 129, 0);
    chk("R3 oversize error", err_at_done, 1);
    chk("R3 no chip-select", cs_falls - falls0, 0);
  endtask

  task automatic t_max;
    set_resp(8'h62, 8'h9D);
    for (int i = 0; i < 128; i++) wmem[i] = 8'(i ^ 8'h55);
    run_xfer(8'h00, 8'h01, 128, 0);
    chk("R3 128 accepted", err_at_done, 0);
    chk("R3 128 frame bits", bitpos, 132 * 8);
    chk("R4 last payload", mlog[131], 8'(127 ^ 8'h55));
  endtask

  task automatic t_busy_start;
    int falls0;
    set_resp(8'h62, 8'h9D);
    wmem[0] = 8'hC3; wmem[1] = 8'h18;
    falls0 = cs_falls;
    run_xfer(8'h00, 8'h44, 2, 30);
    repeat (100) @(negedge clk);
    chk("R9 single frame", cs_falls - falls0, 1);
    chk("R9 reg unchanged", mlog[2], 8'h44);
    chk("R9 op unchanged", mlog[3], 8'h00);
    chk("R9 length unchanged", bitpos, 6 * 8);
    chk("R9 idle after", cs_n, 1);
  endtask

  initial begin
    for (int i = 0; i < 140; i++) mlog[i] = 8'h00;
    for (int i = 0; i < 128; i++) begin wmem[i] = 8'h00; rbuf[i] = 8'h00; end
    set_resp(8'h62, 8'h9D);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write3();
    t_read5();
    t_bad_ack();
    t_reject();
    t_max();
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule